// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for one SDRAM burst. A read or write command loads a starting column. From the next clock the block shows that column, and after that it steps to the next column of the burst on every clock. The order of the columns depends on a programmed burst length and wrap mode. Fixed bursts of 1, 2, 4 or 8 beats stay inside their aligned window and wrap there. The wrap is either sequential, which counts upward, or interleaved, which XORs the start offset with the beat number. Full-page bursts walk across the whole row and wrap from its last column to its first.

The burst length and wrap mode come from a small mode register, which a mode-set strobe loads. Every burst takes a copy of the mode at its command, so a later mode-set cycle changes only the bursts that follow. A new column command may arrive on any clock. It cuts off the running burst, and the new burst starts on the next clock. A terminate input ends a burst early, which is the only way other than a new command to end a full-page burst. The outputs are the current column, a burst-active flag and a done pulse on the last beat of a fixed-length burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `active_o` and `done_o` are 0 and `col_o` is 0. The mode register holds length 1 with sequential wrap.
- R2: A high `mode_set_i` at a clock edge loads the mode register. The length codes on `mode_len_i` are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page, and codes 4 to 6 act as length 1. On `mode_ilv_i`, 0 selects sequential and 1 selects interleaved. A command in the same cycle still uses the previous mode.
- R3: A high `cmd_i` at a clock edge makes `active_o` 1 and `col_o` equal to `start_col_i` in the next cycle. This holds even when a burst is running and even when `stop_i` is high in the same cycle.
- R4: In sequential mode with length BL, beat k carries the low log2(BL) column bits (start + k) mod BL. The upper bits stay those of the start column.
- R5: In interleaved mode, beat k carries the low log2(BL) bits (start XOR k). The upper bits stay those of the start column.
- R6: In full-page mode, beat k is (start + k) mod 2^COL_W, whatever the wrap bit says. The burst runs until a command or `stop_i` arrives, and `done_o` stays 0.
- R7: `done_o` is 1 exactly during beat BL-1 of a fixed-length burst. If no command arrives, `active_o` is 0 in the next cycle.
- R8: A high `stop_i` with no command ends the burst, so `active_o` is 0 in the next cycle.
- R9: A burst keeps the length and wrap it had at its command, even when the mode register is loaded during the burst.
- R10: While no burst is active, `col_o` holds the last column shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Loads the mode register |
| mode_len_i | input | 3 | Burst length code |
| mode_ilv_i | input | 1 | Wrap select: 0 sequential, 1 interleaved |
| cmd_i | input | 1 | Column command, starts a burst |
| start_col_i | input | COL_W | Starting column of the burst |
| stop_i | input | 1 | Terminates the running burst |
| col_o | output | COL_W | Current column address |
| active_o | output | 1 | A burst beat is being shown |
| done_o | output | 1 | Last beat of a fixed-length burst |

## Verification
Each fixed length is run with the same start column in both wrap modes. Start offsets are chosen so that the sequential and interleaved orders differ, which separates the carry-based wrap from the XOR order. Some starts sit near the top of their window or of the row, so a wrap that leaks into the upper bits shows up as a wrong column. A full-page burst is run through 260 beats to cross the row end. Directed cases then cover these interactions:
- restart in the middle of a burst;
- a command and a stop in the same cycle;
- a mode load in the same cycle as a command;
- a mode load during a burst;
- reserved length codes.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } burst_len_e;

    typedef struct packed {
        burst_len_e len;
        logic       ilv;
    } burst_mode_t;

    localparam burst_mode_t MODE_RESET = '{len: LEN_1, ilv: 1'b0};

    // Map a raw code onto a legal length; the reserved codes act as one beat.
    function automatic burst_len_e decode_len(input logic [2:0] code);
        burst_len_e r;
        case (code)
            3'd0:    r = LEN_1;
            3'd1:    r = LEN_2;
            3'd2:    r = LEN_4;
            3'd3:    r = LEN_8;
            3'd7:    r = LEN_PAGE;
            default: r = LEN_1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
    import colgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_i,
    input  logic [2:0]  len_i,
    input  logic        ilv_i,
    output burst_mode_t mode_o
);

    burst_mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (set_i) begin
            mode_d.len = decode_len(len_i);
            mode_d.ilv = ilv_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_i,
    input  burst_mode_t      mode_i,
    output logic             active_o,
    output logic             last_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] start_o,
    output burst_mode_t      mode_o
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] start;
        burst_mode_t      mode;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [COL_W-1:0] final_beat;
    logic             is_page;
    logic             last_beat;

    // Final beat index of a fixed-length burst, taken from the burst's own mode copy.
    always_comb begin
        is_page = 1'b0;
        case (st_q.mode.len)
            LEN_1:    final_beat = COL_W'(0);
            LEN_2:    final_beat = COL_W'(1);
            LEN_4:    final_beat = COL_W'(3);
            LEN_8:    final_beat = COL_W'(7);
            LEN_PAGE: begin
                final_beat = '1;
                is_page    = 1'b1;
            end
            default:  final_beat = COL_W'(0);
        endcase
        last_beat = st_q.active && !is_page && (st_q.beat == final_beat);
    end

    always_comb begin
        st_d = st_q;
        if (cmd_i) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.start  = start_i;
            st_d.mode   = mode_i;
        end else if (st_q.active) begin
            if (stop_i || last_beat) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.beat   <= '0;
            st_q.start  <= '0;
            st_q.mode   <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign last_o   = last_beat;
    assign beat_o   = st_q.beat;
    assign start_o  = st_q.start;
    assign mode_o   = st_q.mode;

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_mode_t      mode_i,
    output logic [COL_W-1:0] col_o
);

    localparam int WIN_W = $clog2(COL_W + 1);

    logic [WIN_W-1:0] win;
    logic [COL_W-1:0] sum_col;
    logic [COL_W-1:0] xor_col;
    logic             use_xor;

    always_comb begin
        case (mode_i.len)
            LEN_1:    win = WIN_W'(0);
            LEN_2:    win = WIN_W'(1);
            LEN_4:    win = WIN_W'(2);
            LEN_8:    win = WIN_W'(3);
            LEN_PAGE: win = WIN_W'(COL_W);
            default:  win = WIN_W'(0);
        endcase
        // Full page always counts upward across the row.
        use_xor = mode_i.ilv && (mode_i.len != LEN_PAGE);
        sum_col = start_i + beat_i;
        xor_col = start_i ^ beat_i;
    end

    // A bit inside the wrap window follows the order; a bit above it keeps the start value.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        localparam logic [WIN_W-1:0] BIT_IDX = WIN_W'(b);
        assign col_o[b] = (win > BIT_IDX) ? (use_xor ? xor_col[b] : sum_col[b])
                                          : start_i[b];
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_set_i,
    input  logic [2:0]       mode_len_i,
    input  logic             mode_ilv_i,
    input  logic             cmd_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             active_o,
    output logic             done_o
);

    burst_mode_t      cur_mode;
    burst_mode_t      run_mode;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] start_col;

    colgen_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mode_set_i),
        .len_i  (mode_len_i),
        .ilv_i  (mode_ilv_i),
        .mode_o (cur_mode)
    );

    colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_i),
        .stop_i   (stop_i),
        .start_i  (start_col_i),
        .mode_i   (cur_mode),
        .active_o (active_o),
        .last_o   (done_o),
        .beat_o   (beat),
        .start_o  (start_col),
        .mode_o   (run_mode)
    );

    colgen_addr_calc #(.COL_W(COL_W)) u_addr (
        .start_i (start_col),
        .beat_i  (beat),
        .mode_i  (run_mode),
        .col_o   (col_o)
    );

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             active_o,
    input logic             done_o
);

    // R7
    done_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> active_o);

    // R3
    cmd_loads_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i |=> (active_o && col_o == $past(start_col_i)));

    // R7
    done_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cmd_i) |=> !active_o);

    // R8
    stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !cmd_i) |=> !active_o);

    // R10
    idle_col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !cmd_i) |=> $stable(col_o));

    // R6
    burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !done_o && !stop_i && !cmd_i) |=> active_o);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_colgen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .col_o       (col_o),
    .active_o    (active_o),
    .done_o      (done_o)
);

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;

    localparam int COL_W = 8;
    localparam int NVEC  = 9;

    // {len code, interleave, start, up to eight expected columns}
    localparam logic [75:0] VEC [NVEC] = '{
        {3'd3, 1'b0, 8'h35, 64'h35363730_31323334},
        {3'd3, 1'b1, 8'h35, 64'h35343736_31303332},
        {3'd2, 1'b0, 8'h1D, 64'h1D1E1F1C_00000000},
        {3'd2, 1'b1, 8'h1D, 64'h1D1C1F1E_00000000},
        {3'd1, 1'b1, 8'h80, 64'h80810000_00000000},
        {3'd1, 1'b0, 8'h81, 64'h81800000_00000000},
        {3'd0, 1'b0, 8'h7F, 64'h7F000000_00000000},
        {3'd3, 1'b0, 8'hFE, 64'hFEFFF8F9_FAFBFCFD},
        {3'd3, 1'b1, 8'hFE, 64'hFEFFFCFD_FAFBF8F9}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_set_i = 1'b0;
    logic [2:0]       mode_len_i = '0;
    logic             mode_ilv_i = 1'b0;
    logic             cmd_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             active_o;
    logic             done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_set_i  (mode_set_i),
        .mode_len_i  (mode_len_i),
        .mode_ilv_i  (mode_ilv_i),
        .cmd_i       (cmd_i),
        .start_col_i (start_col_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .active_o    (active_o),
        .done_o      (done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic beat(input string req, input int col, input bit act, input bit dn);
        check(req, "col", int'(col_o), col);
        check(req, "active", int'(active_o), int'(act));
        check(req, "done", int'(done_o), int'(dn));
    endtask

    task automatic set_mode(input logic [2:0] code, input logic ilv);
        @(negedge clk);
        mode_set_i = 1'b1; mode_len_i = code; mode_ilv_i = ilv;
        @(negedge clk);
        mode_set_i = 1'b0;
    endtask

    // Returns at the negedge where beat 0 is visible.
    task automatic issue(input logic [COL_W-1:0] s);
        @(negedge clk);
        cmd_i = 1'b1; start_col_i = s;
        @(negedge clk);
        cmd_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        beat("R1", 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        beat("R1", 0, 1'b0, 1'b0);
        // R1 default mode is a single beat
        issue(8'h12);
        beat("R1", 8'h12, 1'b1, 1'b1);
        @(negedge clk);
        check("R1", "active after one beat", int'(active_o), 0);

        // R4 R5 R7 R10 vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] code;
            int         len;
            string      req;
            code = VEC[v][75:73];
            len  = 1 << code;
            req  = VEC[v][72] ? "R5" : "R4";
            set_mode(code, VEC[v][72]);
            issue(VEC[v][71:64]);
            for (int i = 0; i < len; i++) begin
                if (i > 0) @(negedge clk);
                beat(req, int'(VEC[v][63 - 8*i -: 8]), 1'b1, i == len - 1);
            end
            @(negedge clk);
            check("R7", "active after last beat", int'(active_o), 0);
            check("R10", "idle col", int'(col_o), int'(VEC[v][63 - 8*(len-1) -: 8]));
        end

        // R3 restart in the middle of a burst
        set_mode(3'd3, 1'b0);
        issue(8'h10);
        @(negedge clk); beat("R3", 8'h11, 1'b1, 1'b0);
        @(negedge clk); beat("R3", 8'h12, 1'b1, 1'b0);
        cmd_i = 1'b1; start_col_i = 8'h47;
        @(negedge clk); cmd_i = 1'b0;
        beat("R3", 8'h47, 1'b1, 1'b0);
        @(negedge clk); beat("R4", 8'h40, 1'b1, 1'b0);
        // R3 command wins over stop
        cmd_i = 1'b1; stop_i = 1'b1; start_col_i = 8'h58;
        @(negedge clk); cmd_i = 1'b0; stop_i = 1'b0;
        beat("R3", 8'h58, 1'b1, 1'b0);
        // R8 stop alone
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check("R8", "active after stop", int'(active_o), 0);
        check("R10", "col held after stop", int'(col_o), 8'h58);
        @(negedge clk);
        check("R10", "col still held", int'(col_o), 8'h58);

        // R9 mode load during a burst
        set_mode(3'd3, 1'b0);
        issue(8'h20);
        mode_set_i = 1'b1; mode_len_i = 3'd1; mode_ilv_i = 1'b0;
        @(negedge clk); mode_set_i = 1'b0;
        beat("R9", 8'h21, 1'b1, 1'b0);
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            beat("R9", 8'h20 + i, 1'b1, i == 7);
        end
        issue(8'h20);
        beat("R9", 8'h20, 1'b1, 1'b0);
        @(negedge clk); beat("R9", 8'h21, 1'b1, 1'b1);

        // R2 mode load and command together use the old mode (length 2)
        @(negedge clk);
        mode_set_i = 1'b1; mode_len_i = 3'd0; cmd_i = 1'b1; start_col_i = 8'h30;
        @(negedge clk); mode_set_i = 1'b0; cmd_i = 1'b0;
        beat("R2", 8'h30, 1'b1, 1'b0);
        @(negedge clk); beat("R2", 8'h31, 1'b1, 1'b1);
        issue(8'h44);
        beat("R2", 8'h44, 1'b1, 1'b1);

        // R2 reserved code acts as length 1
        set_mode(3'd5, 1'b1);
        issue(8'h66);
        beat("R2", 8'h66, 1'b1, 1'b1);
        @(negedge clk);
        check("R2", "reserved code active", int'(active_o), 0);

        // R6 full page, wrap bit ignored, crosses the row end
        set_mode(3'd7, 1'b1);
        issue(8'hFD);
        for (int i = 0; i < 260; i++) begin
            if (i > 0) @(negedge clk);
            beat("R6", (8'hFD + i) & 8'hFF, 1'b1, 1'b0);
        end
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check("R8", "full page stopped", int'(active_o), 0);
        check("R10", "full page col held", int'(col_o), (8'hFD + 259) & 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule